// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass Between Two Clock Domains

This block gives two ports, each on its own clock, a side channel for passing single words to each other without going through any queue. There is one mailbox per direction. The sender offers a word on a valid/ready interface. When the word is taken, it is held in a register owned by the sending clock domain, and a toggle is flipped. That toggle travels through a multi-stage synchronizer into the receiving domain. There it raises a mail flag, which is presented as `valid` on the receiver's interface.

The receiver takes the word by asserting `ready` while the flag is up. This flips an acknowledge toggle, which travels back to the sender. Until the acknowledge arrives, the sender's `ready` stays low, so only one word per direction is ever in flight. The stored word cannot change while the receiver can see it.

Back-pressure rules: a word is transferred on a rising edge of the port clock at which both `valid` and `ready` are high. A sender may hold `valid` at any time. While `ready` is low, `valid` and the data have no effect. A receiver may hold `ready` high permanently. Both port clocks may be unrelated or may be the same clock.

Top module: `mbx_bypass_pair`

## Requirements
- R1: After reset, both transmit `ready` outputs are 1, both receive `valid` outputs are 0 and both receive data buses are all zeros.
- R2: A word accepted on port A's transmit interface appears unchanged on port B's receive data while port B's receive `valid` is 1, and words are delivered in the order they were sent.
- R3: The B-to-A direction works like R2 and does not depend on the A-to-B direction; both directions can carry traffic at the same time.
- R4: On the sender's clock edge where transmit `valid` and `ready` are both 1, the word is taken, and transmit `ready` is 0 from the next cycle.
- R5: A transmit attempt while `ready` is 0 is ignored: the receiver still sees the earlier word and gets no extra delivery.
- R6: While receive `valid` is 1 and receive `ready` is 0, receive `valid` stays 1 and the receive data stays stable on the next receiver cycle.
- R7: A receiver clock edge with receive `valid` and `ready` both 1 clears receive `valid` in the next cycle.
- R8: After the receiver takes the word, the sender's transmit `ready` returns to 1 within 20 sender cycles.
- R9: The receive flag is not yet set at the first sender clock falling edge after the write. It is set within 10 receiver cycles of the write, provided it is not read in the meantime.
- R10: The transfers of R2 and R3 also work when both ports run from one common clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_tx_valid | input | 1 | Port A offers a word for port B |
| a_tx_ready | output | 1 | A-to-B mailbox free; low while a word is outstanding |
| a_tx_data | input | DATA_W | Word from port A |
| a_rx_valid | output | 1 | Mail flag: a word from port B is waiting |
| a_rx_ready | input | 1 | Port A takes the waiting word |
| a_rx_data | output | DATA_W | Word from port B |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_tx_valid | input | 1 | Port B offers a word for port A |
| b_tx_ready | output | 1 | B-to-A mailbox free |
| b_tx_data | input | DATA_W | Word from port B |
| b_rx_valid | output | 1 | Mail flag: a word from port A is waiting |
| b_rx_ready | input | 1 | Port B takes the waiting word |
| b_rx_data | output | DATA_W | Word from port A |

## Verification
The bench builds the block with its defaults: a 36-bit word and two synchronizer stages. At these values the full round trip fits in a few tens of cycles, so the bench can cover the busy window, ignored writes and the return of `ready` with a few directed words. It then runs streams in both directions at once.

Port A runs at 250 MHz and port B from an unrelated slower clock. A second phase switches port B onto port A's clock, which covers the coincident case. The word patterns include all zeros, all ones and alternating bits, so that every data bit is seen to move in both directions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Fewest synchronizer stages the lanes accept.
  localparam int unsigned MBX_MIN_STAGES = 2;

  // Clamp a requested synchronizer depth to a safe minimum.
  function automatic int unsigned mbx_stages(input int unsigned req);
    return (req < MBX_MIN_STAGES) ? MBX_MIN_STAGES : req;
  endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // One flop per stage; the first stage samples the foreign-domain level.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_lane.sv
module mbx_lane #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic              rclk,
  input  logic              rrst_n,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data
);
  localparam int unsigned STG = mbx_pkg::mbx_stages(SYNC_STAGES);

  // Sender domain state.
  logic              req_tgl;
  logic              ack_in_w;
  logic [DATA_W-1:0] word_q;

  // Receiver domain state.
  logic              req_in_r;
  logic              ack_tgl;

  // Free when every request toggle has been answered.
  assign w_ready = (req_tgl == ack_in_w);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      req_tgl <= 1'b0;
      word_q  <= '0;
    end else if (w_valid && w_ready) begin
      req_tgl <= ~req_tgl;
      word_q  <= w_data;
    end
  end

  mbx_sync #(.STAGES(STG)) u_req_sync (
    .clk   (rclk),
    .rst_n (rrst_n),
    .d     (req_tgl),
    .q     (req_in_r)
  );

  // Mail flag: a request seen but not yet acknowledged.
  assign r_valid = req_in_r ^ ack_tgl;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)                 ack_tgl <= 1'b0;
    else if (r_valid && r_ready) ack_tgl <= ~ack_tgl;
  end

  mbx_sync #(.STAGES(STG)) u_ack_sync (
    .clk   (wclk),
    .rst_n (wrst_n),
    .d     (ack_tgl),
    .q     (ack_in_w)
  );

  // Held static by the sender while the flag can be seen.
  assign r_data = word_q;
endmodule

// File: rtl/mbx_bypass_pair.sv
module mbx_bypass_pair #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_tx_valid,
  output logic              a_tx_ready,
  input  logic [DATA_W-1:0] a_tx_data,
  output logic              a_rx_valid,
  input  logic              a_rx_ready,
  output logic [DATA_W-1:0] a_rx_data,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              b_tx_valid,
  output logic              b_tx_ready,
  input  logic [DATA_W-1:0] b_tx_data,
  output logic              b_rx_valid,
  input  logic              b_rx_ready,
  output logic [DATA_W-1:0] b_rx_data
);
  // Port A to port B.
  mbx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_a2b (
    .wclk    (clk_a),
    .wrst_n  (rst_a_n),
    .w_valid (a_tx_valid),
    .w_ready (a_tx_ready),
    .w_data  (a_tx_data),
    .rclk    (clk_b),
    .rrst_n  (rst_b_n),
    .r_valid (b_rx_valid),
    .r_ready (b_rx_ready),
    .r_data  (b_rx_data)
  );

  // Port B to port A.
  mbx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_b2a (
    .wclk    (clk_b),
    .wrst_n  (rst_b_n),
    .w_valid (b_tx_valid),
    .w_ready (b_tx_ready),
    .w_data  (b_tx_data),
    .rclk    (clk_a),
    .rrst_n  (rst_a_n),
    .r_valid (a_rx_valid),
    .r_ready (a_rx_ready),
    .r_data  (a_rx_data)
  );
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_a,
  input logic              rst_a_n,
  input logic              a_tx_valid,
  input logic              a_tx_ready,
  input logic              a_rx_valid,
  input logic              a_rx_ready,
  input logic [DATA_W-1:0] a_rx_data,
  input logic              clk_b,
  input logic              rst_b_n,
  input logic              b_tx_valid,
  input logic              b_tx_ready,
  input logic              b_rx_valid,
  input logic              b_rx_ready,
  input logic [DATA_W-1:0] b_rx_data
);
  a_r4_a_busy_after_write: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_tx_valid && a_tx_ready) |=> !a_tx_ready);

  a_r4_b_busy_after_write: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_tx_valid && b_tx_ready) |=> !b_tx_ready);

  a_r6_b_mail_held: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_rx_valid && !b_rx_ready) |=> (b_rx_valid && $stable(b_rx_data)));

  a_r6_a_mail_held: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_rx_valid && !a_rx_ready) |=> (a_rx_valid && $stable(a_rx_data)));

  a_r7_b_read_clears: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_rx_valid && b_rx_ready) |=> !b_rx_valid);

  a_r7_a_read_clears: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_rx_valid && a_rx_ready) |=> !a_rx_valid);
endmodule

bind mbx_bypass_pair mbx_bypass_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a      (clk_a),
  .rst_a_n    (rst_a_n),
  .a_tx_valid (a_tx_valid),
  .a_tx_ready (a_tx_ready),
  .a_rx_valid (a_rx_valid),
  .a_rx_ready (a_rx_ready),
  .a_rx_data  (a_rx_data),
  .clk_b      (clk_b),
  .rst_b_n    (rst_b_n),
  .b_tx_valid (b_tx_valid),
  .b_tx_ready (b_tx_ready),
  .b_rx_valid (b_rx_valid),
  .b_rx_ready (b_rx_ready),
  .b_rx_data  (b_rx_data)
);

// File: tb/test_mbx_bypass_pair.sv
module test_mbx_bypass_pair;
  localparam int W = 36;

  logic clk_a = 1'b0;
  logic clk_b_free = 1'b0;
  logic coin = 1'b0;
  logic clk_b;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic a_tx_valid = 1'b0, b_tx_valid = 1'b0;
  logic a_rx_ready = 1'b0, b_rx_ready = 1'b0;
  logic [W-1:0] a_tx_data = '0, b_tx_data = '0;
  logic a_tx_ready, b_tx_ready, a_rx_valid, b_rx_valid;
  logic [W-1:0] a_rx_data, b_rx_data;

  int checks = 0;
  int errors = 0;
  bit a_accept = 1'b0, b_accept = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] q_ab[$];
  logic [W-1:0] q_ba[$];

  always #2 clk_a = ~clk_a;        // 250 MHz
  always #2.8 clk_b_free = ~clk_b_free;
  assign clk_b = coin ? clk_a : clk_b_free;

  mbx_bypass_pair i_mbx_bypass_pair (
    .clk_a(clk_a), .rst_a_n(rst_a_n),
    .a_tx_valid(a_tx_valid), .a_tx_ready(a_tx_ready), .a_tx_data(a_tx_data),
    .a_rx_valid(a_rx_valid), .a_rx_ready(a_rx_ready), .a_rx_data(a_rx_data),
    .clk_b(clk_b), .rst_b_n(rst_b_n),
    .b_tx_valid(b_tx_valid), .b_tx_ready(b_tx_ready), .b_tx_data(b_tx_data),
    .b_rx_valid(b_rx_valid), .b_rx_ready(b_rx_ready), .b_rx_data(b_rx_data)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Driver, port A: wait for space (R8), push expected, check busy (R4).
  task automatic send_a(input logic [W-1:0] d);
    int n = 0;
    @(negedge clk_a);
    while (!a_tx_ready && n < 20) begin @(negedge clk_a); n++; end
    chk(a_tx_ready, "R8 a ready returns", W'(a_tx_ready), W'(1));
    a_tx_valid = 1'b1; a_tx_data = d; q_ab.push_back(d);
    @(negedge clk_a);
    a_tx_valid = 1'b0;
    chk(!a_tx_ready, "R4 a busy after write", W'(a_tx_ready), W'(0));
  endtask

  task automatic send_b(input logic [W-1:0] d);
    int n = 0;
    @(negedge clk_b);
    while (!b_tx_ready && n < 20) begin @(negedge clk_b); n++; end
    chk(b_tx_ready, "R8 b ready returns", W'(b_tx_ready), W'(1));
    b_tx_valid = 1'b1; b_tx_data = d; q_ba.push_back(d);
    @(negedge clk_b);
    b_tx_valid = 1'b0;
    chk(!b_tx_ready, "R4 b busy after write", W'(b_tx_ready), W'(0));
  endtask

  // Monitor, port B receive: pop and compare (R2), check clear (R7).
  initial begin
    bit rd_prev = 1'b0;
    forever begin
      @(negedge clk_b);
      if (rd_prev) chk(!b_rx_valid, "R7 b flag clears", W'(b_rx_valid), W'(0));
      rd_prev = 1'b0;
      b_rx_ready = 1'b0;
      if (rst_b_n && b_rx_valid && b_accept) begin
        if (q_ab.size() == 0) chk(1'b0, "R2 unexpected word at b", b_rx_data, '0);
        else begin
          logic [W-1:0] e;
          e = q_ab.pop_front();
          chk(b_rx_data == e, "R2 word at b", b_rx_data, e);
        end
        b_rx_ready = 1'b1;
        rd_prev = 1'b1;
      end
    end
  end

  // Monitor, port A receive (R3).
  initial begin
    bit rd_prev = 1'b0;
    forever begin
      @(negedge clk_a);
      if (rd_prev) chk(!a_rx_valid, "R7 a flag clears", W'(a_rx_valid), W'(0));
      rd_prev = 1'b0;
      a_rx_ready = 1'b0;
      if (rst_a_n && a_rx_valid && a_accept) begin
        if (q_ba.size() == 0) chk(1'b0, "R3 unexpected word at a", a_rx_data, '0);
        else begin
          logic [W-1:0] e;
          e = q_ba.pop_front();
          chk(a_rx_data == e, "R3 word at a", a_rx_data, e);
        end
        a_rx_ready = 1'b1;
        rd_prev = 1'b1;
      end
    end
  end

  // Watchdog.
  initial begin
    #200us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finish_up();
    end
  end

  task automatic wait_drain();
    int n = 0;
    while ((q_ab.size() != 0 || q_ba.size() != 0 || !a_tx_ready || !b_tx_ready) && n < 400) begin
      @(negedge clk_a); n++;
    end
  endtask

  task automatic stream(input int cnt, input string tag);
    fork
      for (int i = 0; i < cnt; i++) send_a({4'h5, 32'(i * 32'h01010101)} ^ {W{i[0]}});
      for (int i = 0; i < cnt; i++) send_b(~{4'hA, 32'(i * 32'h10203)});
    join
    wait_drain();
    chk(q_ab.size() == 0, {tag, " all a-to-b delivered"}, W'(q_ab.size()), '0);
    chk(q_ba.size() == 0, {tag, " all b-to-a delivered"}, W'(q_ba.size()), '0);
  endtask

  initial begin
    repeat (4) @(negedge clk_a);
    // R1 reset state
    chk(a_tx_ready && b_tx_ready, "R1 ready after reset", W'({a_tx_ready, b_tx_ready}), W'(3));
    chk(!a_rx_valid && !b_rx_valid, "R1 flags low after reset", W'({a_rx_valid, b_rx_valid}), '0);
    chk(a_rx_data == '0 && b_rx_data == '0, "R1 data zero after reset", a_rx_data | b_rx_data, '0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (3) @(negedge clk_a);

    // R9 flag latency, receiver holding off.
    send_a({W{1'b1}});
    chk(!b_rx_valid, "R9 flag not yet set", W'(b_rx_valid), '0);
    begin
      int n = 0;
      while (!b_rx_valid && n < 10) begin @(negedge clk_b); n++; end
      chk(b_rx_valid, "R9 flag set in bound", W'(b_rx_valid), W'(1));
    end
    // R5 writes while busy are ignored; R6 word held.
    a_tx_valid = 1'b1; a_tx_data = 36'h0_0000_0001;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_a);
      chk(!a_tx_ready, "R5 stays busy", W'(a_tx_ready), '0);
    end
    a_tx_valid = 1'b0;
    repeat (4) @(negedge clk_b);
    chk(b_rx_valid, "R6 flag held", W'(b_rx_valid), W'(1));
    chk(b_rx_data == {W{1'b1}}, "R5 R6 word unchanged", b_rx_data, {W{1'b1}});
    b_accept = 1'b1;
    repeat (3) @(negedge clk_b);
    repeat (30) @(negedge clk_b);
    chk(q_ab.size() == 0 && !b_rx_valid, "R5 no extra delivery", W'(b_rx_valid), '0);
    chk(a_tx_ready, "R8 a ready back", W'(a_tx_ready), W'(1));

    // R3 the other direction, alternating bits.
    send_b({18{2'b10}});
    repeat (12) @(negedge clk_a);
    chk(a_rx_valid && a_rx_data == {18{2'b10}}, "R3 word waiting at a", a_rx_data, {18{2'b10}});
    a_accept = 1'b1;
    send_a('0);
    send_b({18{2'b01}});
    wait_drain();

    // R2 R3 concurrent streams, unrelated clocks.
    stream(20, "R2 R3 async");

    // R10 coincident clocks.
    coin = 1'b1;
    repeat (4) @(negedge clk_a);
    stream(20, "R10 coincident");

    done = 1'b1;
    finish_up();
  end
endmodule